// File: doc/BRIEF.md
# Queued-Command SPI Master

This block is an SPI bus master fed by a register interface. Software writes 32-bit command words into a four-entry transmit queue. Each word is self-describing. It holds the data to shift out, which chip selects to drive, which of eight attribute registers sets the frame shape, whether the chip select stays asserted after the frame, and whether the queue stops after it. The serial engine pulls one command at a time. It shifts the frame out on MOSI while it shifts MISO in, and pushes the received frame into a four-entry receive queue. Software drains that queue through a pop register.

Each attribute register sets the frame length, the clock polarity, the clock phase and the bit order. A control register starts and stops the engine, sets the resting level of each chip-select line and flushes either queue. A status register carries two sticky flags, each cleared by writing 1: end-of-queue and transmit overflow. End-of-queue can drive an interrupt line. A frame counter counts completed frames, and a command can restart it from zero.

Top module: `spi_cmd_master`

Register map (byte addresses): 0x00 control, 0x04 status, 0x08 interrupt enable, 0x0C push (write), 0x10 pop (read), 0x14 frame counter (read, bits 15:0), 0x20 + 4*n attribute register n (n = 0..7).

## Requirements
- R1: After reset the outputs and registers hold these values:
  - cs_o is all ones, sck_o, mosi_o and irq_o are 0.
  - Control reads 0x003F0000 and status reads 0.
  - Every attribute register reads 0x38000000, which selects an 8-bit frame in mode 0, MSB first.
  - The frame counter reads 0.
- R2: Push word fields:
  - bit 31 continuous select, bits 30:28 attribute index, bit 27 end-of-queue, bit 26 counter clear;
  - bits 21:16 chip-select mask, bits 15:0 data.
  - Every line set in the mask is driven to its active level while the frame runs.
- R3: Frame length is attribute bits 30:27 plus one. Field values below 3 give a 4-bit frame. Only the low frame-length bits of the data are sent.
- R4: Attribute bit 24 set sends and receives LSB first; clear sends MSB first.
- R5: Attribute bit 26 is the clock polarity, which is the level sck_o rests at. Attribute bit 25 is the phase: 0 samples on the leading edge of each bit, 1 samples on the trailing edge. MOSI changes only on the non-sampling edge.
- R6: A received frame is read right-aligned in pop bits 15:0, with the unused upper bits zero. The receive queue holds four frames. While it is full, no new frame starts.
- R7: Continuous select controls the chip select at the end of a frame:
  - With bit 31 set, the chip select stays asserted after the frame until the next frame starts.
  - With bit 31 clear, it returns to its resting level when the frame ends.
- R8: End-of-queue flag and interrupt:
  - When a frame marked end-of-queue finishes, status bit 28 sets; writing 1 to it clears it.
  - While it is set, no new frame starts.
  - irq_o is status bit 28 AND interrupt-enable bit 28.
- R9: A push while the transmit queue holds four commands is dropped and sets status bit 27. Bit 27 stays set until software writes 1 to it.
- R10: A pop from an empty receive queue reads 0 and leaves the queue unchanged.
- R11: Control bit 31 enables the engine; with it clear, no frame starts. Writing 1 to control bit 11 empties the transmit queue. Writing 1 to control bit 10 empties the receive queue.
- R12: Control bits 21:16 set the resting level of each chip-select line. The active level is its inverse.
- R13: The frame counter counts completed frames. A command with bit 26 set resets it to 0 as its frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on the pop address) |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NUM_CS | Chip-select lines |
| irq_o | output | 1 | End-of-queue interrupt |

## Verification
The bench builds the block with HALF_DIV=2, FIFO_DEPTH=4, NUM_CS=6 and NUM_ATTR=8. The short half period keeps even 16-bit frames under a hundred cycles. That puts the receive-full stall and the end-of-queue halt within a few hundred cycles of observation. The four-entry depth means the fifth push with the engine stopped is the overflow case. A fifth frame against a full receive queue shows the stall. MOSI is looped back to MISO, so every popped frame must equal its masked transmit data. A monitor rebuilds each frame from MOSI on the sampling edge that the configured phase and polarity imply.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic        cont;
    logic [2:0]  attr_sel;
    logic        eoq;
    logic        clr_cnt;
    logic [3:0]  rsvd;
    logic [5:0]  cs_mask;
    logic [15:0] data;
  } cmd_t;

  typedef struct packed {
    logic        rsvd_hi;
    logic [3:0]  fmsz;
    logic        cpol;
    logic        cpha;
    logic        lsbf;
    logic [23:0] rsvd_lo;
  } attr_t;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_IEN  = 8'h08;
  localparam logic [7:0] A_PUSH = 8'h0C;
  localparam logic [7:0] A_POP  = 8'h10;
  localparam logic [7:0] A_FCNT = 8'h14;

  localparam int B_RUN  = 31;
  localparam int B_TXFL = 11;
  localparam int B_RXFL = 10;
  localparam int B_EOQ  = 28;
  localparam int B_OVF  = 27;

  localparam logic [31:0] ATTR_RST = 32'h3800_0000;
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  assert_pop_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> $stable(cnt_q));

  assert_push_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int NUM_CS   = 6,
  parameter int HALF_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cmd_valid_i,
  input  cmd_t              cmd_i,
  input  attr_t             attr_i,
  input  logic [NUM_CS-1:0] cs_idle_i,
  input  logic              miso_i,
  output logic              cmd_pop_o,
  output logic              done_o,
  output logic              done_eoq_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] cs_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int EW = $clog2(2 * DATA_W) + 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD} st_e;

  st_e               state_q;
  logic [DW-1:0]     div_q;
  logic [EW-1:0]     edge_q, size_q;
  logic              cpol_q, cpha_q, lsbf_q, cont_q, eoq_q, done_q, sck_q;
  logic [DATA_W-1:0] data_q, rx_q;
  logic [NUM_CS-1:0] sel_q;

  logic          tick, start, sample, last_edge;
  logic [EW-1:0] fsz, k_rx, k_tx, pos_rx, pos_tx;

  assign tick      = (div_q == DW'(HALF_DIV - 1));
  assign start     = (state_q == S_IDLE) && run_i && cmd_valid_i && !done_q;
  assign sample    = cpha_q ? edge_q[0] : ~edge_q[0];
  assign last_edge = (edge_q == (size_q << 1) - EW'(1));
  assign fsz       = (attr_i.fmsz < 4'd3) ? EW'(4) : EW'(attr_i.fmsz) + EW'(1);

  // bit index on the wire; phase 1 advances on the leading edge
  assign k_rx   = edge_q >> 1;
  assign k_tx   = cpha_q ? ((edge_q == '0) ? '0 : (edge_q - EW'(1)) >> 1) : (edge_q >> 1);
  assign pos_rx = lsbf_q ? k_rx : size_q - EW'(1) - k_rx;
  assign pos_tx = lsbf_q ? k_tx : size_q - EW'(1) - k_tx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      div_q   <= '0;
      edge_q  <= '0;
      size_q  <= EW'(8);
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      lsbf_q  <= 1'b0;
      cont_q  <= 1'b0;
      eoq_q   <= 1'b0;
      done_q  <= 1'b0;
      sck_q   <= 1'b0;
      data_q  <= '0;
      rx_q    <= '0;
      sel_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_SETUP;
          div_q   <= '0;
          edge_q  <= '0;
          size_q  <= fsz;
          cpol_q  <= attr_i.cpol;
          cpha_q  <= attr_i.cpha;
          lsbf_q  <= attr_i.lsbf;
          cont_q  <= cmd_i.cont;
          eoq_q   <= cmd_i.eoq;
          data_q  <= cmd_i.data;
          rx_q    <= '0;
          sck_q   <= attr_i.cpol;
          sel_q   <= cmd_i.cs_mask[NUM_CS-1:0];
        end
        S_SETUP: begin
          div_q <= tick ? '0 : div_q + 1'b1;
          if (tick) state_q <= S_SHIFT;
        end
        S_SHIFT: begin
          div_q <= tick ? '0 : div_q + 1'b1;
          if (tick) begin
            sck_q  <= ~sck_q;
            edge_q <= edge_q + 1'b1;
            if (sample) rx_q[pos_rx[3:0]] <= miso_i;
            if (last_edge) state_q <= S_HOLD;
          end
        end
        S_HOLD: begin
          div_q <= tick ? '0 : div_q + 1'b1;
          if (tick) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            if (!cont_q) sel_q <= '0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mosi_o     = (state_q != S_IDLE) && (k_tx < size_q) ? data_q[pos_tx[3:0]] : 1'b0;
  assign cmd_pop_o  = start;
  assign done_o     = done_q;
  assign done_eoq_o = done_q & eoq_q;
  assign rx_data_o  = rx_q;
  assign sck_o      = sck_q;
  assign cs_o       = cs_idle_i ^ sel_q;

  assert_sck_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HOLD) |=> $stable(sck_q));

  assert_halt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !run_i) |=> (state_q == S_IDLE));

  assert_cs_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !cont_q) |-> (sel_q == '0));
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int NUM_CS     = 6,
  parameter int FIFO_DEPTH = 4,
  parameter int NUM_ATTR   = 8,
  parameter int HALF_DIV   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic              irq_o
);
  localparam int IW = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1;

  logic              run_q, eoq_q, ovf_q, ien_q;
  logic [NUM_CS-1:0] idle_q;
  logic [15:0]       fcnt_q;
  logic [31:0]       attr_q [NUM_ATTR];

  logic        wr_ctrl, wr_stat, wr_ien, wr_push, rd_pop, attr_hit;
  logic [IW-1:0] attr_idx;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic [31:0] tx_head;
  logic [DATA_W-1:0] rx_head, eng_rx;
  logic        eng_pop, eng_done, eng_eoq;
  cmd_t        cmd;

  assign wr_ctrl  = reg_we_i && reg_addr_i == A_CTRL;
  assign wr_stat  = reg_we_i && reg_addr_i == A_STAT;
  assign wr_ien   = reg_we_i && reg_addr_i == A_IEN;
  assign wr_push  = reg_we_i && reg_addr_i == A_PUSH;
  assign rd_pop   = reg_re_i && reg_addr_i == A_POP;
  assign attr_hit = reg_addr_i[7:5] == 3'b001;
  assign attr_idx = reg_addr_i[IW+1:2];
  assign cmd      = cmd_t'(tx_head);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      idle_q <= '1;
      ien_q  <= 1'b0;
      eoq_q  <= 1'b0;
      ovf_q  <= 1'b0;
      fcnt_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= reg_wdata_i[B_RUN];
        idle_q <= reg_wdata_i[16 +: NUM_CS];
      end
      if (wr_ien) ien_q <= reg_wdata_i[B_EOQ];
      // a set in the same cycle wins over a software clear
      if (eng_eoq)                           eoq_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[B_EOQ]) eoq_q <= 1'b0;
      if (wr_push && tx_full)                ovf_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[B_OVF]) ovf_q <= 1'b0;
      if (eng_pop && cmd.clr_cnt) fcnt_q <= '0;
      else if (eng_done)          fcnt_q <= fcnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_ATTR; g++) begin : g_attr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          attr_q[g] <= ATTR_RST;
      else if (reg_we_i && attr_hit && attr_idx == IW'(g)) attr_q[g] <= reg_wdata_i;
    end
  end

  spi_cmd_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .flush_i (wr_ctrl && reg_wdata_i[B_TXFL]),
    .push_i  (wr_push),
    .wdata_i (reg_wdata_i),
    .pop_i   (eng_pop),
    .rdata_o (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  spi_cmd_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .flush_i (wr_ctrl && reg_wdata_i[B_RXFL]),
    .push_i  (eng_done),
    .wdata_i (eng_rx),
    .pop_i   (rd_pop),
    .rdata_o (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  spi_cmd_shifter #(.NUM_CS(NUM_CS), .HALF_DIV(HALF_DIV)) u_eng (
    .clk_i, .rst_ni,
    .run_i       (run_q && !eoq_q && !rx_full),
    .cmd_valid_i (!tx_empty),
    .cmd_i       (cmd),
    .attr_i      (attr_t'(attr_q[cmd.attr_sel[IW-1:0]])),
    .cs_idle_i   (idle_q),
    .miso_i      (miso_i),
    .cmd_pop_o   (eng_pop),
    .done_o      (eng_done),
    .done_eoq_o  (eng_eoq),
    .rx_data_o   (eng_rx),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .cs_o        (cs_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[B_RUN]       = run_q;
        reg_rdata_o[16 +: NUM_CS] = idle_q;
      end
      A_STAT: begin
        reg_rdata_o[B_EOQ] = eoq_q;
        reg_rdata_o[B_OVF] = ovf_q;
      end
      A_IEN:  reg_rdata_o[B_EOQ] = ien_q;
      A_POP:  reg_rdata_o[DATA_W-1:0] = rx_empty ? '0 : rx_head;
      A_FCNT: reg_rdata_o[15:0] = fcnt_q;
      default: if (attr_hit) reg_rdata_o = attr_q[attr_idx];
    endcase
  end

  assign irq_o = eoq_q & ien_q;

  assert_drop_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_push && tx_full) |=> ovf_q);

  assert_eoq_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_eoq |=> eoq_q);
endmodule

// File: tb/spi_cmd_master_bench.sv
module spi_cmd_master_bench;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_IEN = 8'h08,
                         A_PUSH = 8'h0C, A_POP = 8'h10, A_FCNT = 8'h14;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, mosi;
  logic [5:0]  cs;
  logic        irq;

  always #2 clk = ~clk;

  spi_cmd_master #(.NUM_CS(6), .FIFO_DEPTH(4), .NUM_ATTR(8), .HALF_DIV(2)) u_spi_cmd_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(mosi), .cs_o(cs), .irq_o(irq));

  int checks = 0, fails = 0;
  logic [31:0] ser_q[$], rx_q[$];
  int  cur_size = 8;
  logic cur_cpol = 0, cur_cpha = 0, cur_lsb = 0;
  logic [5:0] idle_lvl = 6'h3F;
  bit  mon_on = 0, finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); re = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  function automatic logic [31:0] attr(input int fmsz, input bit cpol, input bit cpha, input bit lsb);
    return {1'b0, 4'(fmsz), cpol, cpha, lsb, 24'b0};
  endfunction

  task automatic push(input logic [15:0] d, input bit cont, input int as, input bit eoq,
                      input bit clr, input logic [5:0] mask, input bit exp_ser, input bit exp_rx);
    logic [31:0] m;
    m = (32'd1 << cur_size) - 1;
    if (exp_ser) ser_q.push_back({16'b0, d} & m);
    if (exp_rx)  rx_q.push_back({16'b0, d} & m);
    wr(A_PUSH, {cont, 3'(as), eoq, clr, 4'b0, mask, d});
  endtask

  task automatic pop_chk(input string req);
    logic [31:0] v;
    rd(A_POP, v);
    if (rx_q.size() == 0) check({req, " pop with none expected"}, v, 32'hFFFF_FFFF);
    else check(req, v, rx_q.pop_front());
  endtask

  task automatic wait_eoq(input string req);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(A_STAT, v);
      if (v[28]) return;
    end
    check({req, " eoq timeout"}, 0, 1);
  endtask

  // serial monitor: rebuilds frames from MOSI on the sampling edge
  logic sck_prev = 0, cs_act_prev = 0;
  logic [31:0] acc = 0;
  int nbits = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (cs_act_prev && sck !== sck_prev && sck === (cur_cpol ^ ~cur_cpha)) begin
        if (cur_lsb) acc = acc | (32'(mosi) << nbits);
        else         acc = (acc << 1) | 32'(mosi);
        nbits++;
        if (nbits == cur_size) begin
          if (ser_q.size() == 0) check("R11 unexpected frame", acc, 32'hFFFF_FFFF);
          else check("R4 serial frame", acc, ser_q.pop_front());
          acc = 0; nbits = 0;
        end
      end
      sck_prev    = sck;
      cs_act_prev = (cs ^ idle_lvl) != 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    cyc(3); #1;
    check("R1 cs", 32'(cs), 32'h3F);
    check("R1 sck", 32'(sck), 0);
    check("R1 mosi", 32'(mosi), 0);
    check("R1 irq", 32'(irq), 0);
    rst_n = 1;
    cyc(2);
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h003F0000);
    rd(A_STAT, v); check("R1 stat", v, 0);
    rd(8'h20, v);  check("R1 attr0", v, 32'h38000000);
    rd(8'h3C, v);  check("R1 attr7", v, 32'h38000000);
    rd(A_FCNT, v); check("R1 fcnt", v, 0);
    mon_on = 1;

    // mode 0, 8-bit, MSB first, chip select 0
    wr(8'h20, attr(7, 0, 0, 0));
    wr(A_CTRL, 32'h803F0000);
    push(16'h12A5, 0, 0, 0, 0, 6'h01, 1, 1);
    push(16'h003C, 0, 0, 0, 0, 6'h01, 1, 1);
    push(16'h00F0, 0, 0, 1, 0, 6'h01, 1, 1);
    cyc(6); #1 check("R2 cs active mid frame", 32'(cs), 32'h3E);
    wait_eoq("R8");
    cyc(2); #1 check("R7 cs released", 32'(cs), 32'h3F);
    check("R8 irq masked", 32'(irq), 0);
    rd(A_FCNT, v); check("R13 fcnt three", v, 3);
    for (int i = 0; i < 3; i++) pop_chk("R6 mode0 pop");
    wr(A_STAT, 32'h1000_0000);
    rd(A_STAT, v); check("R8 eoq cleared", v, 0);

    // mode 3, 16-bit, LSB first, continuous select on line 3
    cur_size = 16; cur_cpol = 1; cur_cpha = 1; cur_lsb = 1;
    wr(8'h24, attr(15, 1, 1, 1));
    wr(A_IEN, 32'h1000_0000);
    push(16'hBEEF, 1, 1, 0, 1, 6'h08, 1, 1);
    push(16'h8001, 1, 1, 1, 0, 6'h08, 1, 1);
    wait_eoq("R8");
    #1 check("R8 irq raised", 32'(irq), 1);
    check("R7 cs held with continuous", 32'(cs), 32'h37);
    check("R5 sck rests at polarity 1", 32'(sck), 1);
    rd(A_FCNT, v); check("R13 cleared then two", v, 2);
    pop_chk("R4 lsb pop"); pop_chk("R4 lsb pop");
    wr(A_STAT, 32'h1000_0000);
    #1 check("R8 irq dropped", 32'(irq), 0);

    // end-of-queue halts the queue
    cur_size = 8; cur_cpol = 0; cur_cpha = 0; cur_lsb = 0;
    push(16'h0055, 0, 0, 1, 1, 6'h01, 1, 1);
    push(16'h00AA, 0, 0, 1, 0, 6'h01, 1, 1);
    wait_eoq("R8");
    cyc(100);
    rd(A_FCNT, v); check("R8 halted after eoq", v, 1);
    #1 check("R8 cs idle while halted", 32'(cs), 32'h3F);
    wr(A_STAT, 32'h1000_0000);
    wait_eoq("R8");
    rd(A_FCNT, v); check("R8 resumed after clear", v, 2);
    pop_chk("R6 pop"); pop_chk("R6 pop");
    wr(A_STAT, 32'h1000_0000);

    // size field below 3 gives a 4-bit frame, mode 1
    cur_size = 4; cur_cha_set: begin cur_cpha = 1; end
    wr(8'h28, attr(1, 0, 1, 0));
    push(16'hABCD, 0, 2, 1, 1, 6'h02, 1, 1);
    wait_eoq("R3");
    pop_chk("R3 4-bit frame");
    wr(A_STAT, 32'h1000_0000);

    // per-line resting level
    cur_size = 8; cur_cpha = 0;
    wr(A_CTRL, 32'h803B0000); idle_lvl = 6'h3B;
    cyc(1); #1 check("R12 idle level", 32'(cs), 32'h3B);
    push(16'h0099, 0, 0, 1, 1, 6'h04, 1, 1);
    cyc(6); #1 check("R12 inverted when active", 32'(cs), 32'h3F);
    wait_eoq("R12");
    pop_chk("R12 pop");
    wr(A_STAT, 32'h1000_0000);

    // overflow with engine stopped, then receive-full stall
    wr(A_CTRL, 32'h003F0000); idle_lvl = 6'h3F;
    push(16'h0011, 0, 0, 0, 1, 6'h02, 1, 1);
    push(16'h0022, 0, 0, 0, 0, 6'h02, 1, 1);
    push(16'h0033, 0, 0, 0, 0, 6'h02, 1, 1);
    push(16'h0044, 0, 0, 1, 0, 6'h02, 1, 1);
    push(16'h0077, 0, 0, 1, 0, 6'h02, 0, 0);
    rd(A_STAT, v); check("R9 overflow sticky", v, 32'h0800_0000);
    cyc(50);
    rd(A_FCNT, v); check("R11 nothing sent while stopped", v, 1);
    wr(A_CTRL, 32'h803F0000);
    wait_eoq("R9");
    wr(A_STAT, 32'h1800_0000);
    push(16'h0066, 0, 0, 1, 0, 6'h02, 1, 1);
    cyc(200);
    rd(A_FCNT, v); check("R6 stall on full rx", v, 4);
    rd(A_STAT, v); check("R9 flags cleared", v, 0);
    for (int i = 0; i < 4; i++) pop_chk("R6 drain");
    wait_eoq("R6");
    rd(A_FCNT, v); check("R6 resumed frame", v, 5);
    pop_chk("R6 fifth");
    rd(A_POP, v); check("R10 empty pop zero", v, 0);
    rd(A_POP, v); check("R10 empty pop zero again", v, 0);
    wr(A_STAT, 32'h1000_0000);

    // flushes
    wr(A_CTRL, 32'h003F0000);
    push(16'h0101, 0, 0, 1, 0, 6'h01, 0, 0);
    push(16'h0202, 0, 0, 1, 0, 6'h01, 0, 0);
    wr(A_CTRL, 32'h003F0800);
    wr(A_CTRL, 32'h803F0000);
    cyc(150);
    rd(A_FCNT, v); check("R11 tx flush", v, 5);
    push(16'h0033, 0, 0, 1, 0, 6'h01, 1, 0);
    wait_eoq("R11");
    wr(A_CTRL, 32'h803F0400);
    rd(A_POP, v); check("R11 rx flush", v, 0);
    rd(A_FCNT, v); check("R13 counts on", v, 6);

    cyc(20);
    check("R4 serial queue drained", ser_q.size(), 0);
    check("R6 rx queue drained", rx_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule